// File: doc/BRIEF.md
# Double-Buffered Blit Engine Register Front End

This block sits between a host bus and a 2D drawing engine and presents the engine's setup registers through a 4 KB memory window. Each access uses the full 12-bit offset. The lowest 256 bytes hold the register file. The rest of the window feeds two streaming data channels: offsets 0x100 through 0x3FF push into the source-data channel, and offsets 0x400 through 0xFFF push into the third data channel. A host can therefore stream pixel words with a repeated string-store loop that walks the addresses.

Every setup register exists twice. The staging copy is the one the host bus and the command-buffer port write, and the one a bus read returns. The active copy drives the engine. When the engine is idle, a start request copies the whole staging set into the active set in one edge and raises busy. Busy stays high until the engine reports done. Software and the command buffer can therefore prepare the next operation while the current one runs.

There are four registers: destination offset (0x00), source offset (0x04), stride (0x08) and size (0x0C). In the size register, bits 31:28 and 15:12 have no storage behind them. Every bit of the other three registers is stored, including reserved bits.

Top module: `blit_reg_front`

## Requirements
- R1: After reset, every staging and active register is 0. `engBusy`, `srcChValid`, `ch3Valid` and `wrOverrun` are low.
- R2: A host write to a register offset updates that staging register at the clock edge. A host read returns the staging value in the same cycle. Offset bits [1:0] are ignored, and bits [3:2] select the register: 0 = destination offset, 1 = source offset, 2 = stride, 3 = size.
- R3: In the size register, bits 31:28 and 15:12 always read 0. Every other bit of all four registers reads back the last value written.
- R4: Offsets 0x010 to 0x0FF read as 0. Writes to them change no register.
- R5: A command-buffer write (`cbWrEn`, index `cbIdx` with the same encoding as R2) updates that staging register at the clock edge.
- R6: If the host and the command buffer write the same register in the same cycle, the command-buffer value is kept and the host value is dropped. `wrOverrun` is then high for exactly the next cycle. Writes by the two ports to different registers both take effect and raise no overrun.
- R7: `engStart` while the engine is idle copies all staging values, as they stood before that edge, into the active outputs. `engBusy` is high from the following cycle.
- R8: The active outputs change only on an accepted start. Staging writes while busy are visible to reads but do not reach the active outputs.
- R9: `engStart` while busy is ignored. `engDone` while busy drops `engBusy` on the next cycle, and a later start loads again.
- R10: A write at 0x100–0x3FF makes `srcChValid` high for one cycle, starting the cycle after the write, with `srcChData` equal to the written word. No register changes.
- R11: A write at 0x400–0xFFF makes `ch3Valid` high for one cycle, starting the cycle after the write, with `ch3Data` equal to the written word. No register changes.
- R12: A read anywhere at 0x100–0xFFF returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 12 | Host byte offset within the window |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Host read data, combinational |
| cbWrEn | input | 1 | Command-buffer write strobe |
| cbIdx | input | 2 | Command-buffer register index |
| cbWrData | input | 32 | Command-buffer write data |
| engStart | input | 1 | Engine start request |
| engDone | input | 1 | Engine operation complete |
| engBusy | output | 1 | Operation in progress |
| actDstOffset | output | 32 | Active destination offset |
| actSrcOffset | output | 32 | Active source offset |
| actStride | output | 32 | Active stride |
| actSize | output | 32 | Active width/height |
| srcChValid | output | 1 | Source-data channel push |
| srcChData | output | 32 | Source-data channel word |
| ch3Valid | output | 1 | Third data channel push |
| ch3Data | output | 32 | Third data channel word |
| wrOverrun | output | 1 | One-cycle pulse: host write lost to a command-buffer write |

## Verification
The bench targets the region edges: 0x0FC/0x010 inside the primary region, 0x100/0x3FC and 0x400/0xFFF at the alias limits. A design that decoded too few address bits would alias registers into the data channels, or the reverse. It writes all ones to the size register to expose any storage behind the unbacked bits, and it uses a non-aligned offset to show that byte-offset bits are ignored. It collides host and command-buffer writes on one register and also on two different registers; the wrong priority shows up as the host value surviving, and a loose clash compare shows up as a spurious overrun. It writes staging while busy and issues start while busy, which exposes any design that lets a write through to the active set or reloads during a running operation.

// File: rtl/blit_reg_pkg.sv
package blit_reg_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int REG_NUM  = 4;
  localparam int IDX_W    = $clog2(REG_NUM);
  localparam int OFF_LSB  = 2;
  localparam int PRIM_MSB = 7;
  localparam logic [ADDR_W-1:0] PRIM_END = 12'h0FF;
  localparam logic [ADDR_W-1:0] SRC_END  = 12'h3FF;
  localparam int SIZE_IDX = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic             hostWr;
    logic [IDX_W-1:0] hostIdx;
    logic             cbWr;
    logic [IDX_W-1:0] cbIdx;
    logic             load;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} engState_e;

  // bits that have storage behind them
  function automatic logic [DATA_W-1:0] keepMask(input int idx);
    if (idx == SIZE_IDX) return 32'h0FFF_0FFF;
    return '1;
  endfunction
endpackage

// File: rtl/blit_reg_ctrl.sv
module blit_reg_ctrl
  import blit_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              cbWrEn,
  input  logic [IDX_W-1:0]  cbIdx,
  input  logic              engStart,
  input  logic              engDone,
  output ctrlStrobe_t       strb,
  output logic              engBusy,
  output logic              srcChValid,
  output logic [DATA_W-1:0] srcChData,
  output logic              ch3Valid,
  output logic [DATA_W-1:0] ch3Data,
  output logic              wrOverrun
);
  localparam int SEL_W = PRIM_MSB - OFF_LSB + 1;

  engState_e        engState;
  logic             inPrim, inSrc, inCh3, regHit, hostWrReq, clash;
  logic [IDX_W-1:0] hostIdx;

  always_comb begin
    inPrim    = (busAddr <= PRIM_END);
    inSrc     = !inPrim && (busAddr <= SRC_END);
    inCh3     = (busAddr > SRC_END);
    regHit    = inPrim && (busAddr[PRIM_MSB:OFF_LSB] < SEL_W'(REG_NUM));
    hostIdx   = busAddr[OFF_LSB+IDX_W-1:OFF_LSB];
    hostWrReq = busWrEn && regHit;
    clash     = hostWrReq && cbWrEn && (hostIdx == cbIdx);

    strb.hostWr  = hostWrReq && !clash;
    strb.hostIdx = hostIdx;
    strb.cbWr    = cbWrEn;
    strb.cbIdx   = cbIdx;
    strb.load    = (engState == ENG_IDLE) && engStart;
    strb.rdHit   = busRdEn && regHit;
    strb.rdIdx   = hostIdx;
  end

  assign engBusy = (engState == ENG_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engState <= ENG_IDLE;
    end else begin
      case (engState)
        ENG_IDLE: if (engStart) engState <= ENG_RUN;
        ENG_RUN:  if (engDone)  engState <= ENG_IDLE;
        default:  engState <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcChValid <= 1'b0;
      ch3Valid   <= 1'b0;
      srcChData  <= '0;
      ch3Data    <= '0;
      wrOverrun  <= 1'b0;
    end else begin
      srcChValid <= busWrEn && inSrc;
      ch3Valid   <= busWrEn && inCh3;
      if (busWrEn && inSrc) srcChData <= busWrData;
      if (busWrEn && inCh3) ch3Data   <= busWrData;
      wrOverrun  <= clash;
    end
  end
endmodule

// File: rtl/blit_reg_dpath.sv
module blit_reg_dpath
  import blit_reg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strb,
  input  logic [DATA_W-1:0]               busWrData,
  input  logic [DATA_W-1:0]               cbWrData,
  output logic [DATA_W-1:0]               rdData,
  output logic [REG_NUM-1:0][DATA_W-1:0]  activeRegs
);
  logic [REG_NUM-1:0][DATA_W-1:0] stageRegs;

  for (genvar i = 0; i < REG_NUM; i++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP_M = keepMask(i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageRegs[i] <= '0;
      end else if (strb.cbWr && (strb.cbIdx == IDX_W'(i))) begin
        stageRegs[i] <= cbWrData & KEEP_M;
      end else if (strb.hostWr && (strb.hostIdx == IDX_W'(i))) begin
        stageRegs[i] <= busWrData & KEEP_M;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)          activeRegs[i] <= '0;
      else if (strb.load) activeRegs[i] <= stageRegs[i];
    end
  end

  assign rdData = strb.rdHit ? stageRegs[strb.rdIdx] : '0;
endmodule

// File: rtl/blit_reg_front.sv
module blit_reg_front
  import blit_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              cbWrEn,
  input  logic [IDX_W-1:0]  cbIdx,
  input  logic [DATA_W-1:0] cbWrData,
  input  logic              engStart,
  input  logic              engDone,
  output logic              engBusy,
  output logic [DATA_W-1:0] actDstOffset,
  output logic [DATA_W-1:0] actSrcOffset,
  output logic [DATA_W-1:0] actStride,
  output logic [DATA_W-1:0] actSize,
  output logic              srcChValid,
  output logic [DATA_W-1:0] srcChData,
  output logic              ch3Valid,
  output logic [DATA_W-1:0] ch3Data,
  output logic              wrOverrun
);
  ctrlStrobe_t                    strb;
  logic [REG_NUM-1:0][DATA_W-1:0] activeRegs;

  blit_reg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .cbWrEn(cbWrEn), .cbIdx(cbIdx),
    .engStart(engStart), .engDone(engDone),
    .strb(strb), .engBusy(engBusy),
    .srcChValid(srcChValid), .srcChData(srcChData),
    .ch3Valid(ch3Valid), .ch3Data(ch3Data),
    .wrOverrun(wrOverrun)
  );

  blit_reg_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busWrData(busWrData), .cbWrData(cbWrData),
    .rdData(busRdData), .activeRegs(activeRegs)
  );

  assign actDstOffset = activeRegs[0];
  assign actSrcOffset = activeRegs[1];
  assign actStride    = activeRegs[2];
  assign actSize      = activeRegs[3];
endmodule

// File: rtl/blit_reg_chk.sv
module blit_reg_chk
  import blit_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              cbWrEn,
  input logic [IDX_W-1:0]  cbIdx,
  input logic              engStart,
  input logic              engDone,
  input logic              engBusy,
  input logic [DATA_W-1:0] actDstOffset,
  input logic [DATA_W-1:0] actSrcOffset,
  input logic              srcChValid,
  input logic [DATA_W-1:0] srcChData,
  input logic              ch3Valid,
  input logic [DATA_W-1:0] ch3Data,
  input logic              wrOverrun
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!engBusy && engStart) |=> engBusy); // R7
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(!engBusy && engStart) |=> ($stable(actDstOffset) && $stable(actSrcOffset))); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (engBusy && engDone) |=> !engBusy); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (engBusy && !engDone) |=> engBusy); // R9
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && cbWrEn && busAddr <= PRIM_END && busAddr[PRIM_MSB:OFF_LSB] == 6'(cbIdx))
      |=> wrOverrun); // R6
  AST_SRC_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr > PRIM_END && busAddr <= SRC_END)
      |=> (srcChValid && srcChData == $past(busWrData))); // R10
  AST_CH3_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr > SRC_END) |=> (ch3Valid && ch3Data == $past(busWrData))); // R11
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({srcChValid, ch3Valid})); // R10
  AST_ALIAS_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr > PRIM_END) |-> busRdData == '0); // R12
  AST_SIZE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[ADDR_W-1:OFF_LSB] == 10'h003) |-> (busRdData & 32'hF000_F000) == '0); // R3
endmodule

bind blit_reg_front blit_reg_chk chk_i (.*);

// File: tb/blit_reg_front_tb_top.sv
module blit_reg_front_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic        cbWrEn = 1'b0;
  logic [1:0]  cbIdx = '0;
  logic [31:0] cbWrData = '0;
  logic        engStart = 1'b0, engDone = 1'b0, engBusy;
  logic [31:0] actDstOffset, actSrcOffset, actStride, actSize;
  logic        srcChValid, ch3Valid, wrOverrun;
  logic [31:0] srcChData, ch3Data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  blit_reg_front dut_i (.*);

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h000, 32'h1122_3344, 32'h0,         4'd2},  // R2
    '{1'b0, 12'h000, 32'h0,         32'h1122_3344, 4'd2},
    '{1'b1, 12'h005, 32'hA5A5_A5A5, 32'h0,         4'd2},  // R2 unaligned
    '{1'b0, 12'h004, 32'h0,         32'hA5A5_A5A5, 4'd2},
    '{1'b1, 12'h008, 32'hDEAD_BEEF, 32'h0,         4'd2},
    '{1'b0, 12'h00B, 32'h0,         32'hDEAD_BEEF, 4'd2},
    '{1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0,         4'd3},  // R3 unbacked
    '{1'b0, 12'h00C, 32'h0,         32'h0FFF_0FFF, 4'd3},
    '{1'b1, 12'h000, 32'hF000_0001, 32'h0,         4'd3},  // R3 backed
    '{1'b0, 12'h000, 32'h0,         32'hF000_0001, 4'd3},
    '{1'b1, 12'h010, 32'h1234_5678, 32'h0,         4'd4},  // R4
    '{1'b0, 12'h010, 32'h0,         32'h0,         4'd4},
    '{1'b0, 12'h0FC, 32'h0,         32'h0,         4'd4},
    '{1'b0, 12'h000, 32'h0,         32'hF000_0001, 4'd4},
    '{1'b0, 12'h200, 32'h0,         32'h0,         4'd12}, // R12
    '{1'b0, 12'hC00, 32'h0,         32'h0,         4'd12}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic pulse(input bit doStart);
    @(negedge clk);
    if (doStart) engStart = 1'b1; else engDone = 1'b1;
    @(negedge clk);
    engStart = 1'b0; engDone = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({31'b0, engBusy}, 32'h0, "R1 busy");
    chk(actDstOffset | actSrcOffset | actStride | actSize, 32'h0, "R1 active");
    chk({29'b0, srcChValid, ch3Valid, wrOverrun}, 32'h0, "R1 flags");
    hostRead(12'h008, rd); chk(rd, 32'h0, "R1 staging");

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) hostWrite(VECS[i].addr, VECS[i].data);
      else begin
        hostRead(VECS[i].addr, rd);
        chk(rd, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      end
    end

    // R5 command-buffer write
    @(negedge clk);
    cbWrEn = 1'b1; cbIdx = 2'd2; cbWrData = 32'h0000_55AA;
    @(negedge clk);
    cbWrEn = 1'b0;
    hostRead(12'h008, rd); chk(rd, 32'h0000_55AA, "R5 cb stride");

    // R6 same-register clash
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 12'h004; busWrData = 32'h111;
    cbWrEn = 1'b1; cbIdx = 2'd1; cbWrData = 32'h222;
    @(negedge clk);
    busWrEn = 1'b0; cbWrEn = 1'b0;
    chk({31'b0, wrOverrun}, 32'h1, "R6 overrun set");
    hostRead(12'h004, rd); chk(rd, 32'h222, "R6 cb wins");
    chk({31'b0, wrOverrun}, 32'h0, "R6 overrun one cycle");
    // R6 different registers
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 12'h000; busWrData = 32'h333;
    cbWrEn = 1'b1; cbIdx = 2'd1; cbWrData = 32'h444;
    @(negedge clk);
    busWrEn = 1'b0; cbWrEn = 1'b0;
    chk({31'b0, wrOverrun}, 32'h0, "R6 no overrun");
    hostRead(12'h000, rd); chk(rd, 32'h333, "R6 host kept");
    hostRead(12'h004, rd); chk(rd, 32'h444, "R6 cb kept");

    // R7 load on start
    chk(actDstOffset, 32'h0, "R8 idle writes not active");
    pulse(1'b1);
    chk({31'b0, engBusy}, 32'h1, "R7 busy");
    chk(actDstOffset, 32'h333, "R7 dst");
    chk(actSrcOffset, 32'h444, "R7 src");
    chk(actStride, 32'h0000_55AA, "R7 stride");
    chk(actSize, 32'h0FFF_0FFF, "R7 size");

    // R8 staging write while busy
    hostWrite(12'h000, 32'hABCD);
    chk(actDstOffset, 32'h333, "R8 active held");
    hostRead(12'h000, rd); chk(rd, 32'hABCD, "R8 read staging");

    // R9 start while busy, done, restart
    pulse(1'b1);
    chk(actDstOffset, 32'h333, "R9 start ignored");
    chk({31'b0, engBusy}, 32'h1, "R9 still busy");
    pulse(1'b0);
    chk({31'b0, engBusy}, 32'h0, "R9 done clears");
    pulse(1'b1);
    chk(actDstOffset, 32'hABCD, "R9 reload");
    pulse(1'b0);

    // R10 source channel alias
    hostWrite(12'h100, 32'hCAFE_0001);
    chk({30'b0, srcChValid, ch3Valid}, 32'h2, "R10 src valid");
    chk(srcChData, 32'hCAFE_0001, "R10 src data");
    @(negedge clk);
    chk({31'b0, srcChValid}, 32'h0, "R10 one-cycle");
    hostWrite(12'h3FC, 32'hCAFE_0002);
    chk(srcChData, 32'hCAFE_0002, "R10 top edge");
    hostRead(12'h000, rd); chk(rd, 32'hABCD, "R10 reg untouched");

    // R11 third channel alias
    hostWrite(12'h400, 32'hBEEF_0003);
    chk({30'b0, srcChValid, ch3Valid}, 32'h1, "R11 ch3 valid");
    chk(ch3Data, 32'hBEEF_0003, "R11 ch3 data");
    hostWrite(12'hFFF, 32'hBEEF_0004);
    chk({31'b0, ch3Valid}, 32'h1, "R11 top edge valid");
    chk(ch3Data, 32'hBEEF_0004, "R11 top edge data");
    @(negedge clk);
    chk({31'b0, ch3Valid}, 32'h0, "R11 one-cycle");
    hostRead(12'h00C, rd); chk(rd, 32'h0FFF_0FFF, "R11 reg untouched");

    summary();
  end
endmodule